// File: doc/BRIEF.md
# SDRAM Read Burst Command Sequencer

This block converts read requests from an on-chip bus into the command stream for an SDRAM device that always runs a read burst of 8 columns. The device wraps each burst inside an aligned group of 8 columns. A request carries a bank/row/column start address, a burst kind and a beat count. The sequencer opens the right row with PRECHARGE and ACTIVE as needed, honouring the row-precharge and row-to-column gaps. It then issues one or more READ commands. For incrementing bursts it splits the transfer at each 8-column group edge, so that the device wrap never hands back the wrong columns.

Returned data is not captured here. The block reproduces the timing of each data slot on the read data bus, CAS latency cycles after each READ, and tags every slot as a wanted beat or as surplus. When enabled, it ends the final device burst early with BURST STOP so that no surplus slots appear. Configuration inputs choose SDR (one column per beat, 8 beats per READ) or DDR (two columns per beat, 4 beats per READ), CAS latency 2 or 3, and the two timing gaps. They must be held steady while a request and its data are in flight.

Top module: `rdseq_top`

## Requirements
- R1: After reset, cmd_op is 0 (no command), req_ready is 1 and beat_valid is 0. Command codes on cmd_op: 0 none, 1 ACTIVE, 2 READ, 3 PRECHARGE, 4 BURST STOP.
- R2: A request whose bank already has its row open issues READ as its first command, one cycle after acceptance, with no PRECHARGE or ACTIVE.
- R3: A request to a bank with no open row issues ACTIVE one cycle after acceptance, and the first READ exactly max(cfg_trcd,1) cycles after ACTIVE.
- R4: A request to a bank with a different row open issues PRECHARGE one cycle after acceptance, then ACTIVE exactly max(cfg_trp,1) cycles later, then READ as in R3.
- R5: Let W be 8 beats when cfg_ddr=0 and 4 beats when cfg_ddr=1. In DDR mode column bit 0 is forced to 0. Let o be the beat offset inside the aligned 8-column group: col[2:0] in SDR, col[2:1] in DDR. Incrementing kinds (req_kind 1 fixed length, 2 unspecified length, 3 treated as 2) issue ceil((o+n)/W) READs. The first is at the start column and each later one is at column bits [2:0]=0 of the next group, with the group number wrapping inside the row.
- R6: For incrementing kinds, each further READ comes exactly k cycles after the previous one, where k is the number of requested beats the previous READ supplies: min(remaining, W−o) for the first and min(remaining, W) after that. Later READs are thus issued before the earlier data has arrived.
- R7: For the wrapping kind (req_kind 0), ceil(n/W) READs all go to the start column. Each further READ waits k+CL cycles after the previous one, with k = min(remaining, W).
- R8: Exactly n slots show beat_valid=1 with beat_discard=0 for a request of n beats (1 to 16).
- R9: With cfg_bst_en=0, the last READ yields W−k_last extra slots with beat_discard=1, all after the last wanted beat.
- R10: With cfg_bst_en=1 and k_last<W, BURST STOP is issued exactly k_last cycles after the last READ and no discard slot appears. No BURST STOP is issued when k_last equals W.
- R11: req_ready is high only while the sequencer is idle. It drops in the cycle after acceptance and stays low until the last command of the request has been issued.
- R12: The first beat_valid of a request appears exactly CL cycles after its first READ, with CL=3 when cfg_cas3=1 and CL=2 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_addr | input | BANK_W+ROW_W+COL_W | {bank, row, column} start address |
| req_kind | input | 2 | 0 wrapping, 1 fixed incrementing, 2 open incrementing |
| req_beats | input | BEAT_W | Requested beats, 1 to 16 |
| cfg_trp | input | TIM_W | PRECHARGE-to-ACTIVE gap in cycles |
| cfg_trcd | input | TIM_W | ACTIVE-to-READ gap in cycles |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cfg_ddr | input | 1 | 1 selects DDR (4 beats per READ) |
| cfg_bst_en | input | 1 | Allow BURST STOP truncation |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | READ start column |
| beat_valid | output | 1 | A data slot is on the read bus this cycle |
| beat_discard | output | 1 | That slot is surplus |

## Verification
Directed requests are issued first. They cover a start offset that straddles a group edge in SDR and in DDR, a long wrapping burst that needs several READs, and back-to-back hits, misses and closed banks on one bank. Together they separate the three row paths and the split and wrap column rules. Random requests then vary the bank, a small row set (so hits and conflicts both occur), the offset, the kind, the length, the timing gaps, the CAS latency, the DDR mode and BURST STOP. Each request is compared cycle by cycle with a command schedule and a beat tally computed from the rules above. A wrong gap, a missing split, a misplaced stop or a mis-tagged slot each show up as a distinct mismatch.

// File: rtl/rdseq_pkg.sv
// Shared encodings for the SDRAM read burst sequencer.
package rdseq_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_PRE = 3'd3,
        OP_BST = 3'd4
    } sd_op_e;

    typedef enum logic [1:0] {
        BK_WRAP      = 2'd0,
        BK_INCR_FIX  = 2'd1,
        BK_INCR_OPEN = 2'd2
    } burst_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_ACT, ST_RD, ST_BST
    } seq_state_e;
endpackage

// File: rtl/rdseq_rowtrack.sv
// Open-row table: one valid bit and row per bank, updated from the issued
// command stream. Answers whether a queried bank/row is open and matching.
// Assumes commands are legal; the assertions check that they are.
module rdseq_rowtrack #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              q_open,
    output logic              q_hit
);
    import rdseq_pkg::*;
    localparam int NBANK = 1 << BANK_W;

    logic             open_v   [NBANK];
    logic [ROW_W-1:0] open_row [NBANK];

    // Track row state per bank from ACTIVE and PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) begin
                open_v[b]   <= 1'b0;
                open_row[b] <= '0;
            end
        end else if (sd_op_e'(cmd_op) == OP_ACT) begin
            open_v[cmd_bank]   <= 1'b1;
            open_row[cmd_bank] <= cmd_row;
        end else if (sd_op_e'(cmd_op) == OP_PRE) begin
            open_v[cmd_bank]   <= 1'b0;
        end
    end

    // Lookup for the request being accepted.
    always_comb begin
        q_open = open_v[q_bank];
        q_hit  = open_v[q_bank] && (open_row[q_bank] == q_row);
    end

    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1) |-> !open_v[cmd_bank]); // R3
    AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd3) |-> open_v[cmd_bank]); // R4
    AST_RD_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2) |-> (open_v[cmd_bank] && open_row[cmd_bank] == cmd_row)); // R2
endmodule

// File: rtl/rdseq_cmdfsm.sv
// Command sequencer: accepts a request when idle, opens the row, then issues
// READs split at 8-column groups (incrementing) or repeated at the start
// column (wrapping), and an optional BURST STOP after the last READ.
// Assumes cfg_* inputs are steady while a request is in progress and that
// req_beats is 1..16 (BEAT_W >= 5).
module rdseq_cmdfsm #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BEAT_W = 5,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        req_kind,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic [TIM_W-1:0]  cfg_trcd,
    input  logic              cfg_cas3,
    input  logic              cfg_ddr,
    input  logic              cfg_bst_en,
    input  logic              row_open,
    input  logic              row_hit,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [3:0]        rd_wanted
);
    import rdseq_pkg::*;
    localparam int CNT_W = ((TIM_W > 4) ? TIM_W : 4) + 1;
    localparam int GRP_W = COL_W - 3;

    seq_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [BANK_W-1:0] l_bank;
    logic [ROW_W-1:0]  l_row;
    logic [COL_W-1:0]  l_col;
    logic [BEAT_W-1:0] l_rem;
    logic              l_wrap;
    logic              l_first;

    logic [3:0]        w_sz, offs, space, k;
    logic [BEAT_W-1:0] rem_after;
    logic [CNT_W-1:0]  trp_e, trcd_e, lat, gap;
    logic [COL_W-1:0]  next_col;

    // Per-READ beat share, gaps and the next group's column.
    always_comb begin
        w_sz   = cfg_ddr ? 4'd4 : 4'd8;
        offs   = cfg_ddr ? {2'b00, l_col[2:1]} : {1'b0, l_col[2:0]};
        space  = (l_first && !l_wrap) ? (w_sz - offs) : w_sz;
        k      = (l_rem < BEAT_W'(space)) ? l_rem[3:0] : space;
        rem_after = l_rem - BEAT_W'(k);
        trp_e  = (cfg_trp  == '0) ? CNT_W'(1) : CNT_W'(cfg_trp);
        trcd_e = (cfg_trcd == '0) ? CNT_W'(1) : CNT_W'(cfg_trcd);
        lat    = cfg_cas3 ? CNT_W'(3) : CNT_W'(2);
        gap    = l_wrap ? (CNT_W'(k) + lat) : CNT_W'(k);
        next_col = {l_col[COL_W-1:3] + GRP_W'(1), 3'b000};
    end

    assign req_ready = (st == ST_IDLE);
    assign cmd_bank  = l_bank;
    assign cmd_row   = l_row;

    // Main sequencing: one command at most per cycle, gaps by down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            cmd_op    <= OP_NOP;
            cmd_col   <= '0;
            rd_wanted <= '0;
            l_bank    <= '0;
            l_row     <= '0;
            l_col     <= '0;
            l_rem     <= '0;
            l_wrap    <= 1'b0;
            l_first   <= 1'b0;
        end else begin
            cmd_op    <= OP_NOP;
            rd_wanted <= '0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    l_bank  <= req_bank;
                    l_row   <= req_row;
                    l_col   <= cfg_ddr ? {req_col[COL_W-1:1], 1'b0} : req_col;
                    l_rem   <= req_beats;
                    l_wrap  <= (burst_kind_e'(req_kind) == BK_WRAP);
                    l_first <= 1'b1;
                    cnt     <= '0;
                    st      <= row_hit ? ST_RD : (row_open ? ST_PRE : ST_ACT);
                end
                ST_PRE: begin
                    cmd_op <= OP_PRE;
                    cnt    <= trp_e - CNT_W'(1);
                    st     <= ST_ACT;
                end
                ST_ACT: if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                end else begin
                    cmd_op <= OP_ACT;
                    cnt    <= trcd_e - CNT_W'(1);
                    st     <= ST_RD;
                end
                ST_RD: if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                end else begin
                    cmd_op    <= OP_RD;
                    cmd_col   <= l_col;
                    rd_wanted <= k;
                    l_rem     <= rem_after;
                    l_first   <= 1'b0;
                    if (!l_wrap) l_col <= next_col;
                    if (rem_after != '0) begin
                        cnt <= gap - CNT_W'(1);
                    end else if (cfg_bst_en && (k != w_sz)) begin
                        cnt <= CNT_W'(k) - CNT_W'(1);
                        st  <= ST_BST;
                    end else begin
                        st  <= ST_IDLE;
                    end
                end
                ST_BST: if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                end else begin
                    cmd_op <= OP_BST;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Checker support: cycles elapsed since the last PRECHARGE / ACTIVE.
    logic [5:0] since_pre, since_act;
    logic       pre_seen, act_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= '0; since_act <= '0;
            pre_seen  <= 1'b0; act_seen <= 1'b0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                pre_seen <= 1'b0; act_seen <= 1'b0;
            end
            if (cmd_op == 3'd3) begin since_pre <= 6'd1; pre_seen <= 1'b1; end
            else if (since_pre != 6'd63) since_pre <= since_pre + 6'd1;
            if (cmd_op == 3'd1) begin since_act <= 6'd1; act_seen <= 1'b1; end
            else if (since_act != 6'd63) since_act <= since_act + 6'd1;
        end
    end

    AST_PRE_TO_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1 && pre_seen) |-> (CNT_W'(since_pre) >= trp_e)); // R4
    AST_ACT_TO_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2 && act_seen) |-> (CNT_W'(since_act) >= trcd_e)); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
endmodule

// File: rtl/rdseq_beattag.sv
// Read-bus slot model: delays each READ / BURST STOP by the CAS latency and
// then marks one slot per cycle, wanted for the READ's share of beats and
// surplus after it. A later READ restarts the slot run; BURST STOP ends it.
// Assumes cfg_cas3 and cfg_ddr are steady while data is in flight.
module rdseq_beattag (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_op,
    input  logic [3:0] rd_wanted,
    input  logic       cfg_cas3,
    input  logic       cfg_ddr,
    output logic       beat_valid,
    output logic       beat_discard
);
    import rdseq_pkg::*;
    localparam int DEPTH = 2;

    logic       p_rd  [DEPTH];
    logic       p_bst [DEPTH];
    logic [3:0] p_k   [DEPTH];
    logic       t_rd, t_bst;
    logic [3:0] t_k, w_sz;
    logic [3:0] remain, idx, wanted;

    // Latency delay line for READ and BURST STOP events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                p_rd[i] <= 1'b0; p_bst[i] <= 1'b0; p_k[i] <= '0;
            end
        end else begin
            p_rd[0]  <= (sd_op_e'(cmd_op) == OP_RD);
            p_bst[0] <= (sd_op_e'(cmd_op) == OP_BST);
            p_k[0]   <= rd_wanted;
            for (int i = 1; i < DEPTH; i++) begin
                p_rd[i] <= p_rd[i-1]; p_bst[i] <= p_bst[i-1]; p_k[i] <= p_k[i-1];
            end
        end
    end

    // Tap chosen by CAS latency: stage 0 for 2, stage 1 for 3.
    always_comb begin
        t_rd  = cfg_cas3 ? p_rd[1]  : p_rd[0];
        t_bst = cfg_cas3 ? p_bst[1] : p_bst[0];
        t_k   = cfg_cas3 ? p_k[1]   : p_k[0];
        w_sz  = cfg_ddr ? 4'd4 : 4'd8;
    end

    // Slot generator: one tagged slot per cycle while a burst is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid <= 1'b0; beat_discard <= 1'b0;
            remain <= '0; idx <= '0; wanted <= '0;
        end else if (t_rd) begin
            beat_valid   <= 1'b1;
            beat_discard <= (t_k == 4'd0);
            remain <= w_sz - 4'd1;
            idx    <= 4'd1;
            wanted <= t_k;
        end else if (t_bst) begin
            beat_valid <= 1'b0; beat_discard <= 1'b0;
            remain <= '0;
        end else if (remain != '0) begin
            beat_valid   <= 1'b1;
            beat_discard <= (idx >= wanted);
            idx    <= idx + 4'd1;
            remain <= remain - 4'd1;
        end else begin
            beat_valid <= 1'b0; beat_discard <= 1'b0;
        end
    end

    AST_DISCARD_ONLY_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_discard |-> beat_valid); // R9
    AST_NO_SLOT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        t_bst |=> !beat_valid); // R10
endmodule

// File: rtl/rdseq_top.sv
// Top of the SDRAM read burst sequencer: splits the request address, wires
// the open-row table, the command sequencer and the read-slot tagger.
// Address layout is {bank, row, column}.
module rdseq_top #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BEAT_W = 5,
    parameter int TIM_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
    input  logic [1:0]                      req_kind,
    input  logic [BEAT_W-1:0]               req_beats,
    input  logic [TIM_W-1:0]                cfg_trp,
    input  logic [TIM_W-1:0]                cfg_trcd,
    input  logic                            cfg_cas3,
    input  logic                            cfg_ddr,
    input  logic                            cfg_bst_en,
    output logic [2:0]                      cmd_op,
    output logic [BANK_W-1:0]               cmd_bank,
    output logic [ROW_W-1:0]                cmd_row,
    output logic [COL_W-1:0]                cmd_col,
    output logic                            beat_valid,
    output logic                            beat_discard
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;

    logic [BANK_W-1:0] a_bank;
    logic [ROW_W-1:0]  a_row;
    logic [COL_W-1:0]  a_col;
    logic              row_open, row_hit;
    logic [3:0]        rd_wanted;

    // Address field split.
    always_comb begin
        a_col  = req_addr[COL_W-1:0];
        a_row  = req_addr[COL_W+ROW_W-1:COL_W];
        a_bank = req_addr[ADDR_W-1:COL_W+ROW_W];
    end

    rdseq_rowtrack #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .q_bank(a_bank), .q_row(a_row),
        .q_open(row_open), .q_hit(row_hit)
    );

    rdseq_cmdfsm #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                   .BEAT_W(BEAT_W), .TIM_W(TIM_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(a_bank), .req_row(a_row), .req_col(a_col),
        .req_kind(req_kind), .req_beats(req_beats),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_cas3(cfg_cas3),
        .cfg_ddr(cfg_ddr), .cfg_bst_en(cfg_bst_en),
        .row_open(row_open), .row_hit(row_hit),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .rd_wanted(rd_wanted)
    );

    rdseq_beattag u_tag (
        .clk(clk), .rst_n(rst_n),
        .cmd_op(cmd_op), .rd_wanted(rd_wanted),
        .cfg_cas3(cfg_cas3), .cfg_ddr(cfg_ddr),
        .beat_valid(beat_valid), .beat_discard(beat_discard)
    );
endmodule

// File: tb/tb_rdseq_top.sv
`timescale 1ns/1ps
module tb_rdseq_top;
    localparam int BANK_W = 2, ROW_W = 13, COL_W = 10, BEAT_W = 5, TIM_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [BANK_W+ROW_W+COL_W-1:0] req_addr = '0;
    logic [1:0] req_kind = '0;
    logic [BEAT_W-1:0] req_beats = '0;
    logic [TIM_W-1:0] cfg_trp = '0, cfg_trcd = '0;
    logic cfg_cas3 = 1'b0, cfg_ddr = 1'b0, cfg_bst_en = 1'b0;
    logic [2:0] cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic beat_valid, beat_discard;

    rdseq_top #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                .BEAT_W(BEAT_W), .TIM_W(TIM_W)) dut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Observed events of one request.
    bit rec = 0;
    int ev_op[32], ev_cyc[32], ev_col[32], ev_bank[32], ev_row[32], nev;
    int n_want, n_disc, first_beat, last_want, first_disc;
    always @(negedge clk) if (rec) begin
        if (cmd_op != 3'd0 && nev < 32) begin
            ev_op[nev] = cmd_op; ev_cyc[nev] = cyc; ev_col[nev] = cmd_col;
            ev_bank[nev] = cmd_bank; ev_row[nev] = cmd_row; nev++;
        end
        if (beat_valid) begin
            if (first_beat < 0) first_beat = cyc;
            if (beat_discard) begin n_disc++; if (first_disc < 0) first_disc = cyc; end
            else begin n_want++; last_want = cyc; end
        end
    end

    // Bench model of open rows.
    bit m_open[4];
    int m_row[4];

    int x_op[32], x_cyc[32], x_col[32], nx;
    task automatic add_x(input int op, input int c, input int col);
        x_op[nx] = op; x_cyc[nx] = c; x_col[nx] = col; nx++;
    endtask

    task automatic run_req(input int bank, input int row, input int col,
                           input int kind, input int n);
        int w, o, ce, tp, rem, k, lastk, cl, trp_e, trcd_e, acc, rd0, wd, mask;
        bit first, hit, wrap;
        string tg;
        mask   = (1 << COL_W) - 1;
        w      = cfg_ddr ? 4 : 8;
        ce     = cfg_ddr ? (col & ~1) : col;
        o      = cfg_ddr ? ((ce >> 1) & 3) : (ce & 7);
        cl     = cfg_cas3 ? 3 : 2;
        trp_e  = (cfg_trp == 0) ? 1 : int'(cfg_trp);
        trcd_e = (cfg_trcd == 0) ? 1 : int'(cfg_trcd);
        wrap   = (kind == 0);
        hit    = m_open[bank] && (m_row[bank] == row);

        nev = 0; n_want = 0; n_disc = 0; first_beat = -1; last_want = -1; first_disc = -1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready while idle", int'(req_ready), 1);
        req_addr  = {BANK_W'(bank), ROW_W'(row), COL_W'(col)};
        req_kind  = 2'(kind);
        req_beats = BEAT_W'(n);
        req_valid = 1'b1;
        rec = 1;
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 busy after accept", int'(req_ready), 0);

        // Expected schedule.
        nx = 0; tp = acc + 1;
        if (!hit) begin
            if (m_open[bank]) begin add_x(3, tp, -1); tp += trp_e; end
            add_x(1, tp, -1); tp += trcd_e;
        end
        rem = n; first = 1; lastk = 0; rd0 = tp;
        while (rem > 0) begin
            k = (first && !wrap) ? (w - o) : w;
            if (rem < k) k = rem;
            add_x(2, tp, ce);
            rem -= k;
            if (rem == 0) begin
                lastk = k;
                if (cfg_bst_en && k != w) add_x(4, tp + k, -1);
            end else begin
                tp += wrap ? (k + cl) : k;
                if (!wrap) ce = (((ce >> 3) + 1) << 3) & mask;
            end
            first = 0;
        end
        m_open[bank] = 1; m_row[bank] = row;

        wd = 0;
        while (!req_ready && wd < 400) begin @(negedge clk); wd++; end
        chk(wd < 400, "R11 returns to idle", wd, 0);
        repeat (30) @(negedge clk);
        rec = 0;

        tg = hit ? "R2 command count" : "R5 command count";
        chk(nev == nx, tg, nev, nx);
        for (int i = 0; i < nx && i < nev; i++) begin
            case (x_op[i])
                3: tg = "R4 PRECHARGE";
                1: tg = m_open[bank] && i > 0 ? "R4 ACTIVE" : "R3 ACTIVE";
                2: tg = wrap ? "R7 READ" : (i == 0 && hit ? "R2 READ" : "R6 READ");
                default: tg = "R10 BURST STOP";
            endcase
            chk(ev_op[i] == x_op[i], {tg, " op"}, ev_op[i], x_op[i]);
            chk(ev_cyc[i] == x_cyc[i], {tg, " cycle"}, ev_cyc[i], x_cyc[i]);
            if (x_op[i] == 2)
                chk(ev_col[i] == x_col[i], "R5 READ column", ev_col[i], x_col[i]);
            chk(ev_bank[i] == bank && ev_row[i] == row, "R5 bank/row", ev_row[i], row);
        end
        chk(n_want == n, "R8 wanted beats", n_want, n);
        if (cfg_bst_en)
            chk(n_disc == 0, "R10 no surplus with stop", n_disc, 0);
        else
            chk(n_disc == w - lastk, "R9 surplus beats", n_disc, w - lastk);
        if (n_disc > 0)
            chk(first_disc > last_want, "R9 surplus after wanted", first_disc, last_want + 1);
        chk(first_beat == rd0 + cl, "R12 first beat latency", first_beat, rd0 + cl);
    endtask

    task automatic set_cfg(input int trp, input int trcd, input bit c3,
                           input bit ddr, input bit bst);
        @(negedge clk);
        cfg_trp = TIM_W'(trp); cfg_trcd = TIM_W'(trcd);
        cfg_cas3 = c3; cfg_ddr = ddr; cfg_bst_en = bst;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int s;
        s = int'($urandom(32'd7321));
        for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state out of reset.
        chk(cmd_op == 3'd0, "R1 no command", int'(cmd_op), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(beat_valid == 1'b0, "R1 no beat", int'(beat_valid), 0);

        // Directed: closed bank, SDR, straddling group (R3, R5, R6, R9).
        set_cfg(2, 3, 0, 0, 0);
        run_req(0, 5, 6, 1, 4);
        // Same row again: hit (R2), BURST STOP on (R10), CL3 (R12).
        set_cfg(2, 3, 1, 0, 1);
        run_req(0, 5, 6, 2, 4);
        // Different row, zero gaps clamp to 1 (R4), DDR split (R5).
        set_cfg(0, 0, 0, 1, 0);
        run_req(0, 9, 6, 2, 2);
        // Long wrapping burst in DDR (R7) with stop.
        set_cfg(3, 2, 1, 1, 1);
        run_req(1, 2, 13, 0, 14);
        // Full-group last READ: no stop expected (R10).
        set_cfg(1, 1, 0, 0, 1);
        run_req(1, 2, 0, 2, 16);
        // Group number wraps inside the row (R5).
        run_req(2, 1, (1 << COL_W) - 3, 1, 8);

        // Random mix.
        for (int t = 0; t < 60; t++) begin
            set_cfg(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)));
            run_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)),
                    int'($urandom_range(0, (1 << COL_W) - 1)),
                    int'($urandom_range(0, 3)), int'($urandom_range(1, 16)));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule